// File: doc/BRIEF.md
# Load and Condition-Code Scoreboard

This block tracks which architectural registers are still waiting on load data, and whether a condition-code result is still in flight. The issue stage presents one candidate instruction at a time, with up to two source register indices, a destination index, a load marker and flags for reading and writing the condition code. The block answers in the same cycle whether that instruction may issue. Unrelated instructions keep flowing past an outstanding load or a pending compare.

Issue happens in a cycle where `iss_valid` and `iss_ok` are both high. An issued load marks its destination register as pending. An issued condition-code writer marks the condition code as pending. Load-return and compare-complete events clear those marks again. The block holds no data. It only keeps one pending bit per register, one condition-code flag and a limit on the number of loads in flight.

Top module: `load_cc_scoreboard`

## Requirements
- R1: While `rst_n` is low at a clock edge, every bit of `pend_mask` and `cc_pend` is cleared by that edge.
- R2: When a load issues (`iss_is_load` high), bit `iss_dst` of `pend_mask` is set from the next cycle on. A load always presents its destination with `iss_dst_used` high.
- R3: An issued instruction that is not a load sets no bit of `pend_mask`, even when it writes a destination register.
- R4: `iss_ok` is low while a used source (`iss_src_a` with `iss_src_a_used`, or `iss_src_b` with `iss_src_b_used`) has its bit set in `pend_mask`. Sources whose used flag is low are ignored.
- R5: `iss_ok` is low while `iss_dst_used` is high and bit `iss_dst` of `pend_mask` is set.
- R6: An issued instruction with `iss_cc_wr` high sets `cc_pend` from the next cycle on. `iss_ok` is low for a reader (`iss_cc_rd` high) while `cc_pend` is set. `cc_pend` has no effect on instructions that do not read the condition code.
- R7: A return (`ret_valid` high) clears bit `ret_idx` of `pend_mask` from the next cycle on. A return to a register that is not pending changes nothing.
- R8: At most 2 loads are pending at once. While two bits of `pend_mask` are set, `iss_ok` is low for a load and unaffected for other instructions.
- R9: `cc_done` clears `cc_pend` from the next cycle on. If an issued condition-code writer coincides with `cc_done`, `cc_pend` ends up set.
- R10: In a cycle where `iss_valid` is low or `iss_ok` is low, the candidate instruction changes neither `pend_mask` nor `cc_pend`.
- R11: `iss_ok` is a combinational function of the present candidate fields and the registered state. A return or `cc_done` in the same cycle does not release a stall until the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| iss_valid | input | 1 | Candidate instruction present |
| iss_src_a | input | 5 | First source register index |
| iss_src_a_used | input | 1 | First source is read |
| iss_src_b | input | 5 | Second source register index |
| iss_src_b_used | input | 1 | Second source is read |
| iss_dst | input | 5 | Destination register index |
| iss_dst_used | input | 1 | Destination is written |
| iss_is_load | input | 1 | Candidate is a load |
| iss_cc_rd | input | 1 | Candidate reads the condition code |
| iss_cc_wr | input | 1 | Candidate writes the condition code |
| ret_valid | input | 1 | Load data returned this cycle |
| ret_idx | input | 5 | Register index of the returned load |
| cc_done | input | 1 | Pending condition-code result completed |
| iss_ok | output | 1 | Candidate may issue this cycle |
| pend_mask | output | 32 | Pending bit per register |
| cc_pend | output | 1 | Condition code pending |

## Verification
`iss_ok` responds in the same cycle as the candidate fields, with no register in its path. The bench therefore drives inputs on the falling edge and samples `iss_ok` one time unit later, before the rising edge. `pend_mask` and `cc_pend` pass through one register, so their effect is due one rising edge after the stimulus. The bench samples them one time unit after that edge and compares them with its own model. A reference model predicts both the stall answer and the next state, and directed sequences cover the load limit, the same-cycle set and clear of the condition code, and returns to registers that are not pending.

// File: rtl/sb_pkg.sv
// Package: shared sizes and helpers for the load / condition-code scoreboard.
// Assumes a flat register space indexed by a binary register number.
package sb_pkg;
    localparam int SB_REGS      = 32;
    localparam int SB_IDX_W     = $clog2(SB_REGS);
    localparam int SB_MAX_LOADS = 2;

    // Counts the set bits of a pending mask (callers size the result).
    function automatic int unsigned count_ones(input logic [SB_REGS-1:0] v);
        int unsigned n;
        n = 0;
        for (int i = 0; i < SB_REGS; i++) n += int'(v[i]);
        return n;
    endfunction
endpackage

// File: rtl/sb_reg_track.sv
// Module: per-register pending bits. A return clears one bit and an issued
// load sets one bit. Set takes priority over clear on the same bit.
// Assumes at most one return and one set per cycle.
module sb_reg_track #(
    parameter int REGS  = sb_pkg::SB_REGS,
    parameter int IDX_W = $clog2(REGS),
    parameter int CNT_W = $clog2(REGS + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             set_en,
    input  logic [IDX_W-1:0] set_idx,
    input  logic             clr_en,
    input  logic [IDX_W-1:0] clr_idx,
    output logic [REGS-1:0]  mask,
    output logic [CNT_W-1:0] pend_cnt
);
    logic [REGS-1:0] mask_next;

    // One next-state bit per register.
    for (genvar g = 0; g < REGS; g++) begin : g_bit
        logic hit_set, hit_clr;
        assign hit_set = set_en && (set_idx == IDX_W'(g));
        assign hit_clr = clr_en && (clr_idx == IDX_W'(g));
        assign mask_next[g] = hit_set | (mask[g] & ~hit_clr);
    end

    // Hold the mask register, cleared by reset.
    always_ff @(posedge clk) begin
        if (!rst_n) mask <= '0;
        else        mask <= mask_next;
    end

    // Number of outstanding loads, taken from the registered mask.
    always_comb pend_cnt = CNT_W'(sb_pkg::count_ones(REGS'(mask)));
endmodule

// File: rtl/sb_cc_track.sv
// Module: single condition-code pending flag. An issued writer sets it and
// completion clears it. Set wins when both happen in one cycle.
module sb_cc_track (
    input  logic clk,
    input  logic rst_n,
    input  logic set_en,
    input  logic clr_en,
    output logic pend
);
    // Update the flag: reset first, then set over clear.
    always_ff @(posedge clk) begin
        if (!rst_n)      pend <= 1'b0;
        else if (set_en) pend <= 1'b1;
        else if (clr_en) pend <= 1'b0;
    end
endmodule

// File: rtl/sb_hazard.sv
// Module: combinational issue check. Looks for RAW on the used sources, WAW
// on the destination, a condition-code read against a pending flag, and the
// load-count limit. Reads registered state only.
module sb_hazard #(
    parameter int REGS      = sb_pkg::SB_REGS,
    parameter int IDX_W     = $clog2(REGS),
    parameter int CNT_W     = $clog2(REGS + 1),
    parameter int MAX_LOADS = sb_pkg::SB_MAX_LOADS
) (
    input  logic [REGS-1:0]  mask,
    input  logic [CNT_W-1:0] pend_cnt,
    input  logic             cc_pend,
    input  logic [IDX_W-1:0] src_a,
    input  logic             src_a_used,
    input  logic [IDX_W-1:0] src_b,
    input  logic             src_b_used,
    input  logic [IDX_W-1:0] dst,
    input  logic             dst_used,
    input  logic             is_load,
    input  logic             cc_rd,
    output logic             ok
);
    localparam logic [CNT_W-1:0] LIMIT = CNT_W'(MAX_LOADS);

    logic raw_hit, waw_hit, cc_hit, cap_hit;

    // Evaluate each hazard class and combine them.
    always_comb begin
        raw_hit = (src_a_used && mask[src_a]) || (src_b_used && mask[src_b]);
        waw_hit = dst_used && mask[dst];
        cc_hit  = cc_rd && cc_pend;
        cap_hit = is_load && (pend_cnt >= LIMIT);
        ok      = !(raw_hit || waw_hit || cc_hit || cap_hit);
    end
endmodule

// File: rtl/load_cc_scoreboard.sv
// Module: top of the scoreboard. It ties the register tracker, the condition-
// code tracker and the hazard check together. An instruction issues when
// iss_valid and iss_ok are both high. Loads must present dst with dst_used.
module load_cc_scoreboard #(
    parameter int REGS      = sb_pkg::SB_REGS,
    parameter int MAX_LOADS = sb_pkg::SB_MAX_LOADS,
    localparam int IDX_W    = $clog2(REGS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             iss_valid,
    input  logic [IDX_W-1:0] iss_src_a,
    input  logic             iss_src_a_used,
    input  logic [IDX_W-1:0] iss_src_b,
    input  logic             iss_src_b_used,
    input  logic [IDX_W-1:0] iss_dst,
    input  logic             iss_dst_used,
    input  logic             iss_is_load,
    input  logic             iss_cc_rd,
    input  logic             iss_cc_wr,
    input  logic             ret_valid,
    input  logic [IDX_W-1:0] ret_idx,
    input  logic             cc_done,
    output logic             iss_ok,
    output logic [REGS-1:0]  pend_mask,
    output logic             cc_pend
);
    localparam int CNT_W = $clog2(REGS + 1);

    logic             fire;
    logic [CNT_W-1:0] pend_cnt;

    // An instruction is accepted only when it is valid and free of hazards.
    always_comb fire = iss_valid && iss_ok;

    sb_reg_track #(.REGS(REGS), .IDX_W(IDX_W), .CNT_W(CNT_W)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .set_en(fire && iss_is_load), .set_idx(iss_dst),
        .clr_en(ret_valid), .clr_idx(ret_idx),
        .mask(pend_mask), .pend_cnt(pend_cnt)
    );

    sb_cc_track u_cc (
        .clk(clk), .rst_n(rst_n),
        .set_en(fire && iss_cc_wr), .clr_en(cc_done),
        .pend(cc_pend)
    );

    sb_hazard #(.REGS(REGS), .IDX_W(IDX_W), .CNT_W(CNT_W), .MAX_LOADS(MAX_LOADS)) u_haz (
        .mask(pend_mask), .pend_cnt(pend_cnt), .cc_pend(cc_pend),
        .src_a(iss_src_a), .src_a_used(iss_src_a_used),
        .src_b(iss_src_b), .src_b_used(iss_src_b_used),
        .dst(iss_dst), .dst_used(iss_dst_used),
        .is_load(iss_is_load), .cc_rd(iss_cc_rd),
        .ok(iss_ok)
    );
endmodule

// File: rtl/load_cc_scoreboard_chk.sv
// Checker: temporal properties of the scoreboard, attached by bind.
module load_cc_scoreboard_chk #(
    parameter int REGS      = 32,
    parameter int MAX_LOADS = 2,
    parameter int IDX_W     = $clog2(REGS)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             iss_valid,
    input logic [IDX_W-1:0] iss_src_a,
    input logic             iss_src_a_used,
    input logic [IDX_W-1:0] iss_dst,
    input logic             iss_is_load,
    input logic             iss_cc_rd,
    input logic             iss_cc_wr,
    input logic             cc_done,
    input logic             iss_ok,
    input logic [REGS-1:0]  pend_mask,
    input logic             cc_pend
);
    assert_reset_clear_R1: assert property (@(posedge clk)
        !rst_n |=> (pend_mask == '0 && !cc_pend));

    assert_load_marks_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (iss_valid && iss_ok && iss_is_load) |=> pend_mask[$past(iss_dst)]);

    assert_raw_stall_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (iss_ok && iss_src_a_used) |-> !pend_mask[iss_src_a]);

    assert_cc_read_stall_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (iss_ok && iss_cc_rd) |-> !cc_pend);

    assert_load_cap_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(pend_mask) <= MAX_LOADS);

    assert_cc_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (cc_done && !(iss_valid && iss_ok && iss_cc_wr)) |=> !cc_pend);
endmodule

bind load_cc_scoreboard load_cc_scoreboard_chk #(.REGS(REGS), .MAX_LOADS(MAX_LOADS)) u_chk (
    .clk(clk), .rst_n(rst_n), .iss_valid(iss_valid),
    .iss_src_a(iss_src_a), .iss_src_a_used(iss_src_a_used),
    .iss_dst(iss_dst), .iss_is_load(iss_is_load),
    .iss_cc_rd(iss_cc_rd), .iss_cc_wr(iss_cc_wr), .cc_done(cc_done),
    .iss_ok(iss_ok), .pend_mask(pend_mask), .cc_pend(cc_pend)
);

// File: tb/load_cc_scoreboard_test.sv
module load_cc_scoreboard_test;
    localparam int CLK_PERIOD = 10;
    localparam int REGS       = 32;
    localparam int MAXL       = 2;
    localparam int RAND_CYC   = 4000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic iss_valid = 0, a_used = 0, b_used = 0, d_used = 0, is_load = 0;
    logic cc_rd = 0, cc_wr = 0, ret_valid = 0, cc_done = 0;
    logic [4:0] src_a = 0, src_b = 0, dst = 0, ret_idx = 0;
    logic iss_ok, cc_pend;
    logic [REGS-1:0] pend_mask;

    logic [REGS-1:0] m_mask = '0;
    logic            m_cc = 1'b0;
    int checks = 0, fails = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    load_cc_scoreboard uut (
        .clk(clk), .rst_n(rst_n), .iss_valid(iss_valid),
        .iss_src_a(src_a), .iss_src_a_used(a_used),
        .iss_src_b(src_b), .iss_src_b_used(b_used),
        .iss_dst(dst), .iss_dst_used(d_used), .iss_is_load(is_load),
        .iss_cc_rd(cc_rd), .iss_cc_wr(cc_wr),
        .ret_valid(ret_valid), .ret_idx(ret_idx), .cc_done(cc_done),
        .iss_ok(iss_ok), .pend_mask(pend_mask), .cc_pend(cc_pend)
    );

    function automatic int ones(input logic [REGS-1:0] v);
        int n = 0;
        for (int i = 0; i < REGS; i++) n += int'(v[i]);
        return n;
    endfunction

    // Expected stall answer from the requirements; returns the tag of the cause.
    function automatic string why_stall();
        if ((a_used && m_mask[src_a]) || (b_used && m_mask[src_b])) return "R4";
        if (d_used && m_mask[dst]) return "R5";
        if (cc_rd && m_cc) return "R6";
        if (is_load && ones(m_mask) >= MAXL) return "R8";
        return "";
    endfunction

    task automatic check(input bit good, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!good) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic drive(input bit v, input int a, input bit au, input int b, input bit bu,
                         input int d, input bit du, input bit ld, input bit cr, input bit cw,
                         input bit rv, input int ri, input bit cd);
        iss_valid = v; src_a = 5'(a); a_used = au; src_b = 5'(b); b_used = bu;
        dst = 5'(d); d_used = du; is_load = ld; cc_rd = cr; cc_wr = cw;
        ret_valid = rv; ret_idx = 5'(ri); cc_done = cd;
    endtask

    // One cycle: inputs already driven after a falling edge.
    task automatic step();
        string cause, mtag;
        bit exp_ok, fire;
        logic [REGS-1:0] nm;
        logic ncc;
        #1;
        cause = why_stall();
        exp_ok = (cause == "");
        check(iss_ok === exp_ok, exp_ok ? "R11" : cause, 64'(iss_ok), 64'(exp_ok));
        fire = iss_valid && exp_ok;
        nm = m_mask;
        if (ret_valid) nm[ret_idx] = 1'b0;
        if (fire && is_load) nm[dst] = 1'b1;
        ncc = m_cc;
        if (cc_done) ncc = 1'b0;
        if (fire && cc_wr) ncc = 1'b1;
        if (fire && is_load) mtag = "R2";
        else if (ret_valid) mtag = "R7";
        else if (iss_valid && !fire) mtag = "R10";
        else mtag = "R3";
        @(posedge clk); #1;
        check(pend_mask === nm, mtag, 64'(pend_mask), 64'(nm));
        check(cc_pend === ncc, cc_done ? "R9" : "R6", 64'(cc_pend), 64'(ncc));
        m_mask = nm; m_cc = ncc;
        @(negedge clk);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        fails++; checks++;
        $display("FAIL watchdog actual=running expected=done");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd5150));
        repeat (3) @(posedge clk);
        #1;
        check(pend_mask === '0, "R1", 64'(pend_mask), 64'd0);
        check(cc_pend === 1'b0, "R1", 64'(cc_pend), 64'd0);
        @(negedge clk); rst_n = 1'b1;

        // R2: load r3 sets its bit
        drive(1, 0,0, 0,0, 3,1, 1, 0,0, 0,0, 0); step();
        // R5: second load to r3 stalls (WAW)
        drive(1, 0,0, 0,0, 3,1, 1, 0,0, 0,0, 0); step();
        // R4: reader of r3 stalls; unused source b=r3 is ignored
        drive(1, 3,1, 0,0, 9,1, 0, 0,0, 0,0, 0); step();
        drive(1, 1,1, 3,0, 9,1, 0, 0,0, 0,0, 0); step();
        // R3: ALU write to r4 leaves mask untouched
        drive(1, 1,1, 2,1, 4,1, 0, 0,0, 0,0, 0); step();
        // R8: second load fills capacity, third stalls, ALU op still flows
        drive(1, 0,0, 0,0, 5,1, 1, 0,0, 0,0, 0); step();
        drive(1, 0,0, 0,0, 6,1, 1, 0,0, 0,0, 0); step();
        drive(1, 1,1, 2,1, 7,1, 0, 0,0, 0,0, 0); step();
        // R11: return this cycle does not release a load stalled this cycle
        drive(1, 0,0, 0,0, 6,1, 1, 0,0, 1,5, 0); step();
        // R7: return to a non-pending register changes nothing
        drive(0, 0,0, 0,0, 0,0, 0, 0,0, 1,20, 0); step();
        drive(1, 0,0, 0,0, 6,1, 1, 0,0, 1,3, 0); step();
        // R6: compare sets cc; reader stalls; non-reader flows
        drive(1, 1,1, 2,1, 0,0, 0, 0,1, 0,0, 0); step();
        drive(1, 1,1, 0,0, 0,0, 0, 1,0, 0,0, 0); step();
        drive(1, 1,1, 0,0, 8,1, 0, 0,0, 0,0, 0); step();
        // R9: done with a new writer keeps cc set; done alone clears it
        drive(1, 1,1, 0,0, 0,0, 0, 0,1, 0,0, 1); step();
        drive(0, 0,0, 0,0, 0,0, 0, 0,1, 0,0, 1); step();
        // R10: invalid load does not mark anything
        drive(1, 0,0, 0,0, 0,0, 0, 0,0, 1,6, 0); step();
        drive(0, 0,0, 0,0, 11,1, 1, 0,1, 0,0, 0); step();

        // Random traffic: small index range to force hazards.
        for (int c = 0; c < RAND_CYC; c++) begin
            bit ld = ($urandom % 3) == 0;
            int ri = $urandom % 8;
            if (m_mask != '0 && ($urandom % 2)) begin
                for (int k = 0; k < REGS; k++) if (m_mask[(ri + k) % REGS]) begin ri = (ri + k) % REGS; break; end
            end
            drive(($urandom % 4) != 0, $urandom % 8, $urandom % 2, $urandom % 8, $urandom % 2,
                  $urandom % 8, ld ? 1'b1 : 1'($urandom % 2), ld,
                  ($urandom % 3) == 0, ($urandom % 4) == 0,
                  ($urandom % 3) == 0, ri, ($urandom % 4) == 0);
            step();
        end

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule